// File: doc/BRIEF.md
# Transport Packet Buffer Writer

This block accepts a stream of 32-bit words that make up 188-byte transport packets (47 words each) and writes them, one word per memory request, into a host buffer with room for a fixed number of packets (eight by default, 1504 bytes). Filling starts at a base address that software programs. Each word address is 4 bytes above the previous one. Completed packets are counted. When the count reaches a programmable threshold, a buffer-end event is latched. Words that arrive after every slot has been filled are dropped and an overflow event is latched.

A single 32-bit control/status word holds the live packet count, the threshold, the latched events, their mask bits, a write-one acknowledge and an active-low run bit that holds the stream logic in reset. Software is expected to work as follows. It programs the base address and releases the run bit. On each buffer-end interrupt it reads the count and drains the buffer. It then writes the base address again, which rearms filling at the first slot and clears the count. The interrupt line is driven only by pending, unmasked buffer-end or overflow events.

Top module: `ts_dma_writer`

## Requirements
- R1: After reset the control word (offset 0x24) reads 0x00027004: count 0, run bit 15 clear, mask bits 17, 14, 13 and 12 set, threshold 4, no event latched. The irq output is low and no memory request is made.
- R2: While run bit 15 is 0, input words are accepted (in_ready high) and discarded. No memory request is made, the count stays 0 and no overflow is latched.
- R3: The n-th word accepted since the last rearm is written at base + 4*n (n counts from 0), with mem_wdata equal to in_data. Consecutive packets occupy consecutive 188-byte slots.
- R4: Bits 31:24 of the control word hold the packet count. It rises by one in the cycle after a packet's 47th word is granted and never exceeds 8.
- R5: A memory request that is not granted stays asserted, with mem_addr and mem_wdata unchanged, until the cycle in which mem_gnt is high.
- R6: Buffer-end status (bit 16) is latched when the count steps onto the threshold (bits 6:0). A threshold of 0 never latches it.
- R7: A word that arrives while all 8 slots are full is accepted without a memory request and discarded, and overflow status (bit 11) is latched.
- R8: Writing offset 0x20 loads the base address, which reads back at 0x20. The same write clears the count and restarts filling at the base.
- R9: irq is high exactly when (bit 16 set and mask bit 17 clear) or (bit 11 set and mask bit 14 clear).
- R10: Writing the control word with bit 8 set clears latched bits 16, 11 and 10. Bit 8 always reads 0.
- R11: Almost-full status (bit 10) latches while afull_in is high, and lock status (bit 9) follows lock_in. Neither drives irq, whatever mask bits 13 and 12 hold.
- R12: Clearing bit 15 in the middle of a packet drops the partial packet. Setting it again restarts with count 0 at the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset (0x20 base, 0x24 control word) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (0 for other offsets) |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input packet word |
| in_ready | output | 1 | Input word taken this cycle |
| mem_req | output | 1 | Memory word-write request |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Word to write |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| afull_in | input | 1 | Almost-full condition from downstream |
| lock_in | input | 1 | Receiver lock indication |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every threshold from 1 to 8 over a complete fill, followed by an overflow packet, under three memory stall patterns. A design whose threshold compare is off by one would latch the buffer-end event one packet early or late. A design that wrote while full would overwrite the slot past the end of the buffer, and its count would run past 8. Each word's address is checked against base + 4*n, which exposes a slot stride that drops or repeats the 47th word and an address that moves while a request is stalled. Further cases cover rearming after a full buffer, a stream reset in the middle of a packet, threshold 0, masked events, and events that must never raise the interrupt. A wrong case shows up as a count that is not 0 or addresses that resume mid-buffer after rearm, as stray or missing irq pulses, or as acknowledged bits that stay set.

// File: rtl/ts_dma_pkg.sv
package ts_dma_pkg;
    // bit positions inside the control/status word
    localparam int CNT_LSB    = 24;
    localparam int B_DE_MASK  = 17;
    localparam int B_DE       = 16;
    localparam int B_RUN      = 15;
    localparam int B_OVR_MASK = 14;
    localparam int B_AF_MASK  = 13;
    localparam int B_LK_MASK  = 12;
    localparam int B_OVR      = 11;
    localparam int B_AF       = 10;
    localparam int B_LOCK     = 9;
    localparam int B_ACK      = 8;

    localparam logic [5:0] OFS_BASE = 6'h20;
    localparam logic [5:0] OFS_CSR  = 6'h24;

    typedef struct packed {
        logic       de_mask;
        logic       ovr_mask;
        logic       af_mask;
        logic       lk_mask;
        logic       run;
        logic [6:0] thr;
    } cfg_t;
endpackage

// File: rtl/ts_dma_fill.sv
module ts_dma_fill
    import ts_dma_pkg::*;
#(
    parameter int PKT_WORDS = 47,
    parameter int BUF_PKTS  = 8,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              arm,
    input  logic [ADDR_W-1:0] arm_base,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    output logic [ADDR_W-1:0] base,
    output logic              pkt_done,
    output logic              drop,
    output logic [CNT_W-1:0]  count
);
    localparam int WIDX_W = $clog2(PKT_WORDS);
    localparam int OFS_W  = $clog2(PKT_WORDS * BUF_PKTS + 1);
    localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(PKT_WORDS - 1);
    localparam logic [CNT_W-1:0]  FULL_C = CNT_W'(BUF_PKTS);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [WIDX_W-1:0] widx;
        logic [OFS_W-1:0]  ofs;
        logic [CNT_W-1:0]  cnt;
    } fill_t;

    fill_t st_d, st_q;
    logic  full, accept;

    always_comb begin
        full      = (st_q.cnt == FULL_C);
        mem_req   = run && !full && in_valid;
        accept    = mem_req && mem_gnt;
        in_ready  = !run || full || mem_gnt;
        drop      = in_valid && run && full;
        pkt_done  = accept && (st_q.widx == LAST_W);
        mem_addr  = st_q.base + ADDR_W'({st_q.ofs, 2'b00});
        mem_wdata = in_data;
        base      = st_q.base;
        count     = st_q.cnt;

        st_d = st_q;
        if (arm) st_d.base = arm_base;
        if (arm || !run) begin
            st_d.widx = '0;
            st_d.ofs  = '0;
            st_d.cnt  = '0;
        end else if (accept) begin
            st_d.ofs = st_q.ofs + 1'b1;
            if (st_q.widx == LAST_W) begin
                st_d.widx = '0;
                if (!full) st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.widx = st_q.widx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: count stays within the buffer size
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_C);
    // R5: stalled request holds address and data
    a_r5_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !arm && run && in_valid) |=>
            (mem_req && $stable(mem_addr)) || !in_valid || !run);
    // R3: each accepted word moves the address up by 4
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !arm && run) |=> mem_addr == $past(mem_addr) + ADDR_W'(4));
    // R8: rearm empties the buffer
    a_r8_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (count == '0 && mem_addr == $past(arm_base)));
endmodule

// File: rtl/ts_dma_csr.sv
module ts_dma_csr
    import ts_dma_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int THR_RESET = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wdata,
    input  logic             pkt_done,
    input  logic [CNT_W-1:0] count,
    input  logic             drop,
    input  logic             afull_in,
    input  logic             lock_in,
    output cfg_t             cfg,
    output logic [31:0]      csr_word,
    output logic             irq
);
    typedef struct packed {
        cfg_t cfg;
        logic de;
        logic ovr;
        logic af;
    } csr_t;

    csr_t r_d, r_q;
    logic hit_thr, ack;

    always_comb begin
        ack     = wr_en && wdata[B_ACK];
        hit_thr = pkt_done && (r_q.cfg.thr != '0) &&
                  ((CNT_W + 1)'(r_q.cfg.thr) == (CNT_W + 1)'(count) + 1'b1);

        r_d = r_q;
        if (wr_en) begin
            r_d.cfg.de_mask  = wdata[B_DE_MASK];
            r_d.cfg.ovr_mask = wdata[B_OVR_MASK];
            r_d.cfg.af_mask  = wdata[B_AF_MASK];
            r_d.cfg.lk_mask  = wdata[B_LK_MASK];
            r_d.cfg.run      = wdata[B_RUN];
            r_d.cfg.thr      = wdata[6:0];
        end
        if (ack) begin
            r_d.de  = 1'b0;
            r_d.ovr = 1'b0;
            r_d.af  = 1'b0;
        end
        if (hit_thr)  r_d.de  = 1'b1;
        if (drop)     r_d.ovr = 1'b1;
        if (afull_in) r_d.af  = 1'b1;

        cfg      = r_q.cfg;
        irq      = (r_q.de && !r_q.cfg.de_mask) || (r_q.ovr && !r_q.cfg.ovr_mask);
        csr_word = '0;
        csr_word[31:CNT_LSB]  = 8'(count);
        csr_word[B_DE_MASK]   = r_q.cfg.de_mask;
        csr_word[B_DE]        = r_q.de;
        csr_word[B_RUN]       = r_q.cfg.run;
        csr_word[B_OVR_MASK]  = r_q.cfg.ovr_mask;
        csr_word[B_AF_MASK]   = r_q.cfg.af_mask;
        csr_word[B_LK_MASK]   = r_q.cfg.lk_mask;
        csr_word[B_OVR]       = r_q.ovr;
        csr_word[B_AF]        = r_q.af;
        csr_word[B_LOCK]      = lock_in;
        csr_word[6:0]         = r_q.cfg.thr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q              <= '0;
            r_q.cfg.de_mask  <= 1'b1;
            r_q.cfg.ovr_mask <= 1'b1;
            r_q.cfg.af_mask  <= 1'b1;
            r_q.cfg.lk_mask  <= 1'b1;
            r_q.cfg.thr      <= 7'(THR_RESET);
        end else begin
            r_q <= r_d;
        end
    end

    // R6: buffer-end only appears after a completed packet
    a_r6_de_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.de) |-> $past(pkt_done));
    // R10: latched events leave only through acknowledge
    a_r10_de_ack_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.de) |-> $past(wr_en && wdata[B_ACK]));
    a_r10_ovr_ack_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.ovr) |-> $past(wr_en && wdata[B_ACK]));
endmodule

// File: rtl/ts_dma_writer.sv
module ts_dma_writer
    import ts_dma_pkg::*;
#(
    parameter int PKT_WORDS = 47,
    parameter int BUF_PKTS  = 8,
    parameter int THR_RESET = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        in_ready,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_gnt,
    input  logic        afull_in,
    input  logic        lock_in,
    output logic        irq
);
    localparam int CNT_W = 8;

    cfg_t             cfg;
    logic [31:0]      base, csr_word;
    logic             pkt_done, drop, arm, csr_wr;
    logic [CNT_W-1:0] count;

    assign arm    = reg_wr && (reg_addr == OFS_BASE);
    assign csr_wr = reg_wr && (reg_addr == OFS_CSR);

    ts_dma_fill #(
        .PKT_WORDS(PKT_WORDS), .BUF_PKTS(BUF_PKTS),
        .ADDR_W(32), .DATA_W(32), .CNT_W(CNT_W)
    ) u_fill (
        .clk(clk), .rst_n(rst_n), .run(cfg.run), .arm(arm),
        .arm_base(reg_wdata), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .base(base),
        .pkt_done(pkt_done), .drop(drop), .count(count)
    );

    ts_dma_csr #(.CNT_W(CNT_W), .THR_RESET(THR_RESET)) u_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(csr_wr), .wdata(reg_wdata),
        .pkt_done(pkt_done), .count(count), .drop(drop),
        .afull_in(afull_in), .lock_in(lock_in),
        .cfg(cfg), .csr_word(csr_word), .irq(irq)
    );

    always_comb begin
        unique case (reg_addr)
            OFS_BASE: reg_rdata = base;
            OFS_CSR:  reg_rdata = csr_word;
            default:  reg_rdata = '0;
        endcase
    end

    // R9: interrupt only from pending, unmasked buffer-end or overflow
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((csr_word[B_DE] && !csr_word[B_DE_MASK]) ||
                 (csr_word[B_OVR] && !csr_word[B_OVR_MASK])));
    // R7: a dropped word latches overflow
    a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> csr_word[B_OVR]);
    // R2: no write while held in reset
    a_r2_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_word[B_RUN] |-> !mem_req);
endmodule

// File: tb/ts_dma_writer_tb.sv
module ts_dma_writer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = 6'h24;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, mem_req, irq;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        afull_in = 1'b0, lock_in = 1'b0;

    always #5 clk = ~clk;

    ts_dma_writer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .afull_in(afull_in), .lock_in(lock_in), .irq(irq)
    );

    int errs = 0, checks = 0;
    int stall_mode = 0;
    int unsigned lfsr = 32'h1234_5678;
    logic [31:0] exp_base = '0;
    int exp_idx = 0;
    bit run_exp = 0, full_exp = 0;
    bit prev_stall = 0;
    logic [31:0] prev_addr = '0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory grant pattern
    always @(posedge clk) begin
        #1;
        lfsr = lfsr * 1103515245 + 12345;
        case (stall_mode)
            0: mem_gnt = 1'b1;
            1: mem_gnt = (((lfsr >> 16) % 4) != 0);
            default: mem_gnt = (((lfsr >> 16) % 4) == 0);
        endcase
    end

    // write monitor: R2, R3, R5, R7
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) begin
                if (!run_exp) chk("R2 request while held", 32'd1, 32'd0);
                if (full_exp) chk("R7 request while full", 32'd1, 32'd0);
                chk("R3 address", mem_addr, exp_base + 32'(4 * exp_idx));
                chk("R3 data", mem_wdata, in_data);
                if (prev_stall) chk("R5 stalled address", mem_addr, prev_addr);
                if (mem_gnt) exp_idx++;
            end else if (prev_stall && in_valid) begin
                chk("R5 request withdrawn", 32'd0, 32'd1);
            end
            prev_stall = mem_req && !mem_gnt;
            prev_addr  = mem_addr;
        end
    end

    function automatic logic [31:0] cfg(bit run, bit dem, bit ovm, bit afm,
                                        bit lkm, logic [6:0] thr, bit ack);
        logic [31:0] v = '0;
        v[17] = dem; v[15] = run; v[14] = ovm; v[13] = afm; v[12] = lkm;
        v[8] = ack; v[6:0] = thr;
        return v;
    endfunction

    task automatic reg_write(logic [5:0] a, logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 6'h24;
    endtask

    task automatic reg_read(logic [5:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata; reg_addr = 6'h24;
    endtask

    task automatic send_word(logic [31:0] d);
        in_valid = 1'b1; in_data = d;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic send_pkt(int n);
        for (int w = 0; w < 47; w++) send_word({n[15:0], w[15:0]});
    endtask

    task automatic arm(logic [31:0] b);
        reg_write(6'h20, b);
        exp_base = b; exp_idx = 0; full_exp = 0;
    endtask

    logic [31:0] rd;

    initial begin
        #1_500_000;
        errs++; checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        reg_read(6'h24, rd); chk("R1 control word", rd, 32'h0002_7004);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);

        // R2 words dropped while held
        send_pkt(99);
        reg_read(6'h24, rd);
        chk("R2 count", {24'd0, rd[31:24]}, 32'd0);
        chk("R2 no overflow", {31'd0, rd[11]}, 32'd0);

        // threshold sweep with full fill and overflow
        for (int t = 1; t <= 8; t++) begin
            logic [31:0] b;
            stall_mode = t % 3;
            b = 32'h1000_0000 + 32'(t << 12);
            reg_write(6'h24, cfg(1, 0, 0, 1, 1, 7'(t), 1));
            run_exp = 1;
            arm(b);
            reg_read(6'h20, rd); chk("R8 base readback", rd, b);
            reg_read(6'h24, rd); chk("R8 count after arm", {24'd0, rd[31:24]}, 32'd0);
            for (int p = 1; p <= 8; p++) begin
                send_pkt(p);
                if (p == 8) full_exp = 1;
                reg_read(6'h24, rd);
                chk("R4 count", {24'd0, rd[31:24]}, 32'(p));
                if (p == t) begin
                    chk("R6 end at threshold", rd, {8'(p), 6'd0, 1'b0, 1'b1, 1'b1,
                        1'b0, 1'b1, 1'b1, 3'b000, 2'b00, 7'(t)});
                    chk("R9 irq on end", {31'd0, irq}, 32'd1);
                    reg_write(6'h24, cfg(1, 0, 0, 1, 1, 7'(t), 1));
                    reg_read(6'h24, rd);
                    chk("R10 end cleared", {31'd0, rd[16]}, 32'd0);
                    chk("R10 ack reads 0", {31'd0, rd[8]}, 32'd0);
                    chk("R9 irq released", {31'd0, irq}, 32'd0);
                end else begin
                    chk("R6 no end off threshold", {31'd0, rd[16]}, 32'd0);
                end
            end
            send_pkt(50);
            reg_read(6'h24, rd);
            chk("R7 overflow latched", {31'd0, rd[11]}, 32'd1);
            chk("R4 count saturated", {24'd0, rd[31:24]}, 32'd8);
            chk("R7 words written", 32'(exp_idx), 32'(8 * 47));
            chk("R9 irq on overflow", {31'd0, irq}, 32'd1);
            reg_write(6'h24, cfg(1, 0, 0, 1, 1, 7'(t), 1));
            chk("R10 overflow cleared", {31'd0, irq}, 32'd0);
            arm(b + 32'h800);
            send_pkt(7);
            reg_read(6'h24, rd);
            chk("R8 rearm count", {24'd0, rd[31:24]}, 32'd1);
        end
        stall_mode = 1;

        // R9 masked buffer-end, then unmasked
        reg_write(6'h24, cfg(1, 1, 0, 1, 1, 7'd1, 1));
        arm(32'h2000_0000);
        send_pkt(1);
        reg_read(6'h24, rd);
        chk("R9 masked end latched", {31'd0, rd[16]}, 32'd1);
        chk("R9 masked end no irq", {31'd0, irq}, 32'd0);
        reg_write(6'h24, cfg(1, 0, 0, 1, 1, 7'd1, 0));
        chk("R9 unmask raises irq", {31'd0, irq}, 32'd1);
        reg_write(6'h24, cfg(1, 0, 0, 0, 0, 7'd1, 1));

        // R11 almost-full and lock never interrupt
        @(posedge clk); #1 afull_in = 1'b1; lock_in = 1'b1;
        @(posedge clk); #1 afull_in = 1'b0;
        reg_read(6'h24, rd);
        chk("R11 almost-full latched", {31'd0, rd[10]}, 32'd1);
        chk("R11 lock follows", {31'd0, rd[9]}, 32'd1);
        chk("R11 no irq", {31'd0, irq}, 32'd0);
        reg_write(6'h24, cfg(1, 0, 0, 0, 0, 7'd1, 1));
        reg_read(6'h24, rd);
        chk("R10 almost-full cleared", {31'd0, rd[10]}, 32'd0);
        chk("R11 lock stays", {31'd0, rd[9]}, 32'd1);
        #1 lock_in = 1'b0; #1;
        reg_read(6'h24, rd);
        chk("R11 lock drops", {31'd0, rd[9]}, 32'd0);

        // R12 stream reset mid-packet
        reg_write(6'h24, cfg(1, 0, 0, 1, 1, 7'd0, 1));
        arm(32'h3000_0000);
        for (int w = 0; w < 20; w++) send_word(32'hC000_0000 + 32'(w));
        reg_write(6'h24, cfg(0, 0, 0, 1, 1, 7'd0, 0));
        run_exp = 0;
        for (int w = 0; w < 5; w++) send_word(32'hD000_0000 + 32'(w));
        reg_read(6'h24, rd);
        chk("R12 held count", {24'd0, rd[31:24]}, 32'd0);
        reg_write(6'h24, cfg(1, 0, 0, 1, 1, 7'd0, 0));
        run_exp = 1; exp_idx = 0;
        send_pkt(3);
        send_pkt(4);
        reg_read(6'h24, rd);
        chk("R12 restart count", {24'd0, rd[31:24]}, 32'd2);
        chk("R6 threshold 0 never ends", {31'd0, rd[16]}, 32'd0);
        chk("R12 words from base", 32'(exp_idx), 32'd94);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule